// File: doc/BRIEF.md
# Revertive Glitch-Free Reference Clock Selector

This block chooses, for each of two downstream PLL channels, which of two reference clocks (primary or secondary) drives that channel's reference input. External activity detectors report whether each reference is available. The block filters those flags and feeds them to a per-channel decision. The decision comes from the channel's 2-bit mode code and, for one code, from a decoded three-level select pin. The chosen clock is then passed through a handshaked clock gate, so that the output never carries a runt pulse.

In automatic operation a channel prefers the primary. It falls back to the secondary when the primary is lost and returns to the primary once it is back. When both references are lost, the channel stays parked on the secondary, raises loss-of-signal and asks for its outputs to be disabled. A secondary-path enable output lets the crystal input stage be shut off for good after the first move from secondary to primary, unless a keep option is set.

All pins are plain control, status or clock signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. Status outputs are level signals in the `clk_sys` domain. The two availability flags are asynchronous levels. When a stopped reference restarts, its clock should run for a few cycles before its availability flag is raised again.

Top module: `refsel_dual`

## Requirements
- R1: In automatic operation, when the primary is reported unavailable (and the secondary available), the channel moves to the secondary; `cur_sel` bit = 1 means secondary, 0 means primary (bit 0 = channel 1, bit 1 = channel 2).
- R2: In automatic operation, when the primary becomes available again, the channel returns to the primary.
- R3: With both references unavailable, an automatic channel stays on the secondary until one of them becomes available again.
- R4: `los` is high exactly while both filtered availability flags are low; while `los` is high, both `out_dis` bits are high.
- R5: Mode code 00 is automatic with the primary preferred, 10 forces the primary and 11 forces the secondary, whatever the availability flags say.
- R6: With mode code 01 the pin decides. With `pin_lvl` 00 (low), channel 1 is forced to the primary and channel 2 to the secondary. With 01 (mid), channel 1 is automatic and channel 2 is forced to the secondary. With 10 or 11 (high), both channels are automatic.
- R7: Every switchover is glitch-free: no high or low pulse on `clk_out` is shorter than the shorter half period of the two references.
- R8: If the departing reference has stopped, the switchover still completes, after 8 cycles of the incoming clock.
- R9: A change on an availability flag takes effect only after 4 consecutive equal `clk_sys` samples; a shorter pulse changes no selection.
- R10: With `xtal_keep` = 0, `sec_path_en` falls after the first completed move from secondary to primary on an automatic channel and stays low until reset; with `xtal_keep` = 1 it stays high.
- R11: Reset sets `sec_path_en` high, treats both references as available so that automatic channels start on the primary, and holds `out_dis` high until a channel's first selection has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Control clock for filtering and decisions |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pri | input | 1 | Primary reference clock |
| clk_sec | input | 1 | Secondary reference clock |
| pri_ok | input | 1 | Primary available (asynchronous level) |
| sec_ok | input | 1 | Secondary available (asynchronous level) |
| mode_a | input | 2 | Mode code of channel 1 |
| mode_b | input | 2 | Mode code of channel 2 |
| pin_lvl | input | 2 | Decoded select pin: 00 low, 01 mid, 10/11 high |
| xtal_keep | input | 1 | Keep the secondary path enabled after the first return to primary |
| clk_out | output | 2 | Selected clock per channel |
| los | output | 1 | Both references unavailable |
| out_dis | output | 2 | Per-channel output disable request |
| cur_sel | output | 2 | Per-channel completed selection (1 = secondary) |
| sec_path_en | output | 1 | Secondary input path enable |

## Verification
The selection is tried under four groups of patterns:
- Availability flags toggled one at a time and together. This separates fallback and revert from the parked state when both references are lost.
- Every mode code and pin level. This shows that forced channels ignore the flags while automatic ones follow them.
- A two-cycle flag pulse, which separates the debounce from a real loss.
- A primary that stops dead at its switchover, which proves the timeout bypass.

Pulse widths on both clock outputs are watched throughout for runts. The secondary-path enable is checked once with the keep option clear and once with it set.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic {
    SRC_PRI = 1'b0,
    SRC_SEC = 1'b1
  } src_e;

  typedef enum logic [1:0] {
    EFF_AUTO = 2'd0,
    EFF_PRI  = 2'd1,
    EFF_SEC  = 2'd2
  } eff_e;

  localparam logic [1:0] MODE_AUTO = 2'b00;
  localparam logic [1:0] MODE_PIN  = 2'b01;
  localparam logic [1:0] MODE_PRI  = 2'b10;
  localparam logic [1:0] MODE_SEC  = 2'b11;

  localparam logic [1:0] LVL_LOW = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;

  // Effective behaviour of a channel from its mode code and the pin level.
  function automatic eff_e decode_mode(input logic [1:0] m, input logic [1:0] lvl,
                                       input int ch);
    eff_e r;
    case (m)
      MODE_AUTO: r = EFF_AUTO;
      MODE_PRI:  r = EFF_PRI;
      MODE_SEC:  r = EFF_SEC;
      default: begin
        if (lvl == LVL_LOW)      r = (ch == 1) ? EFF_PRI : EFF_SEC;
        else if (lvl == LVL_MID) r = (ch == 1) ? EFF_AUTO : EFF_SEC;
        else                     r = EFF_AUTO;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/refsel_filt.sv
module refsel_filt #(
  parameter int SYNC    = 2,
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic ok
);
  localparam int CW = $clog2(SAMPLES + 1);

  logic [SYNC-1:0] sy;
  logic [CW-1:0]   cnt;
  logic            s;

  assign s = sy[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy  <= '1;
      cnt <= '0;
      ok  <= 1'b1;
    end else begin
      sy <= {sy[SYNC-2:0], raw};
      if (s == ok) begin
        cnt <= '0;
      end else if (cnt == CW'(SAMPLES - 1)) begin
        ok  <= s;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    if (SAMPLES >= 4) begin : g_chk
      // R9: a new filtered level was seen on at least the last four samples
      a_r9_debounce: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ok) |-> ($past(s, 1) == ok && $past(s, 2) == ok &&
                          $past(s, 3) == ok && $past(s, 4) == ok));
    end
  endgenerate

endmodule

// File: rtl/refsel_gate.sv
module refsel_gate #(
  parameter int SYNC = 2,
  parameter int TMO  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic oth_en,
  output logic en,
  output logic ovr
);
  localparam int TW = $clog2(TMO + 1);

  logic [SYNC-1:0] want_sy;
  logic [SYNC-1:0] oth_sy;
  logic [TW-1:0]   cnt;
  logic            ws;
  logic            os;
  logic            tmo;
  logic            go;

  assign ws  = want_sy[SYNC-1];
  assign os  = oth_sy[SYNC-1];
  assign tmo = (cnt == TW'(TMO));
  assign go  = ws & (~os | tmo | ovr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_sy <= '0;
      oth_sy  <= '0;
      cnt     <= '0;
    end else begin
      want_sy <= {want_sy[SYNC-2:0], want};
      oth_sy  <= {oth_sy[SYNC-2:0], oth_en};
      if (ws && os && !en && !ovr) begin
        if (!tmo) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

  // Enable and override change only while this clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      ovr <= 1'b0;
    end else begin
      en  <= go;
      ovr <= ws & os & (tmo | ovr);
    end
  end

  // R7: a gate that is no longer wanted closes at the next falling edge
  a_r7_gate_off: assert property (@(negedge clk) disable iff (!rst_n)
    !ws |=> !en);
  // R8: the forced takeover never starts before the wait has run out
  a_r8_force_wait: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(cnt) == TW'(TMO));

endmodule

// File: rtl/refsel_chan.sv
module refsel_chan
  import refsel_pkg::*;
#(
  parameter int CH   = 1,
  parameter int SYNC = 2,
  parameter int TMO  = 8
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic       clk_p,
  input  logic       clk_s,
  input  logic       pv,
  input  logic       sv,
  input  logic       los,
  input  logic [1:0] mode,
  input  logic [1:0] lvl,
  output logic       clk_o,
  output logic       cur_sel,
  output logic       out_dis,
  output logic       pri_ret
);
  eff_e       eff;
  src_e       sel_req;
  logic [1:0] rclk;
  logic [1:0] want;
  logic [1:0] en;
  logic [1:0] ovr;
  logic [SYNC-1:0] ack_p_sy;
  logic [SYNC-1:0] ack_s_sy;
  logic       ack_p_q;
  logic       ack_s_q;
  logic       done;
  logic       rise_p;
  logic       rise_s;

  assign eff = decode_mode(mode, lvl, CH);

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      sel_req <= SRC_PRI;
    end else begin
      case (eff)
        EFF_PRI: sel_req <= SRC_PRI;
        EFF_SEC: sel_req <= SRC_SEC;
        default: sel_req <= pv ? SRC_PRI : SRC_SEC;
      endcase
    end
  end

  assign rclk    = {clk_s, clk_p};
  assign want[0] = (sel_req == SRC_PRI);
  assign want[1] = (sel_req == SRC_SEC);

  for (genvar i = 0; i < 2; i++) begin : g_gate
    refsel_gate #(.SYNC(SYNC), .TMO(TMO)) u_gate (
      .clk    (rclk[i]),
      .rst_n  (rst_n),
      .want   (want[i]),
      .oth_en (en[1-i]),
      .en     (en[i]),
      .ovr    (ovr[i])
    );
  end

  assign clk_o = (clk_p & en[0] & ~ovr[1]) | (clk_s & en[1] & ~ovr[0]);

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      ack_p_sy <= '0;
      ack_s_sy <= '0;
      ack_p_q  <= 1'b0;
      ack_s_q  <= 1'b0;
      cur_sel  <= 1'b0;
      done     <= 1'b0;
    end else begin
      ack_p_sy <= {ack_p_sy[SYNC-2:0], en[0]};
      ack_s_sy <= {ack_s_sy[SYNC-2:0], en[1]};
      ack_p_q  <= ack_p_sy[SYNC-1];
      ack_s_q  <= ack_s_sy[SYNC-1];
      if (rise_s)      cur_sel <= 1'b1;
      else if (rise_p) cur_sel <= 1'b0;
      if (rise_s || rise_p) done <= 1'b1;
    end
  end

  assign rise_p  = ack_p_sy[SYNC-1] & ~ack_p_q;
  assign rise_s  = ack_s_sy[SYNC-1] & ~ack_s_q;
  assign pri_ret = rise_p & cur_sel & (eff == EFF_AUTO);
  assign out_dis = los | ~done;

  // R3: with both references gone an automatic channel requests the secondary
  a_r3_park: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!pv && !sv && eff == EFF_AUTO) |=> sel_req == SRC_SEC);
  // R5: a forced code overrides the availability flags
  a_r5_forced: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (eff == EFF_PRI && !pv) |=> sel_req == SRC_PRI);
  // R4: loss of signal always disables the outputs
  a_r4_los_dis: assert property (@(posedge clk_sys) disable iff (!rst_n)
    los |-> out_dis);

endmodule

// File: rtl/refsel_dual.sv
module refsel_dual
  import refsel_pkg::*;
#(
  parameter int SYNC    = 2,
  parameter int SAMPLES = 4,
  parameter int TMO     = 8
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       pri_ok,
  input  logic       sec_ok,
  input  logic [1:0] mode_a,
  input  logic [1:0] mode_b,
  input  logic [1:0] pin_lvl,
  input  logic       xtal_keep,
  output logic [1:0] clk_out,
  output logic       los,
  output logic [1:0] out_dis,
  output logic [1:0] cur_sel,
  output logic       sec_path_en
);
  localparam int NCH = 2;

  logic [1:0]     raw_ok;
  logic [1:0]     flt_ok;
  logic [NCH-1:0] pri_ret;
  logic [1:0]     modes [NCH];

  assign raw_ok   = {sec_ok, pri_ok};
  assign modes[0] = mode_a;
  assign modes[1] = mode_b;

  for (genvar i = 0; i < 2; i++) begin : g_filt
    refsel_filt #(.SYNC(SYNC), .SAMPLES(SAMPLES)) u_filt (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .raw   (raw_ok[i]),
      .ok    (flt_ok[i])
    );
  end

  assign los = ~flt_ok[0] & ~flt_ok[1];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    refsel_chan #(.CH(c + 1), .SYNC(SYNC), .TMO(TMO)) u_chan (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .clk_p   (clk_pri),
      .clk_s   (clk_sec),
      .pv      (flt_ok[0]),
      .sv      (flt_ok[1]),
      .los     (los),
      .mode    (modes[c]),
      .lvl     (pin_lvl),
      .clk_o   (clk_out[c]),
      .cur_sel (cur_sel[c]),
      .out_dis (out_dis[c]),
      .pri_ret (pri_ret[c])
    );
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)                   sec_path_en <= 1'b1;
    else if (!xtal_keep && |pri_ret) sec_path_en <= 1'b0;
  end

  // R10: once shut off, the secondary path stays off until reset
  a_r10_sticky: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !sec_path_en |=> !sec_path_en);
  // R10: with the keep option set the path is never shut off
  a_r10_keep: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (sec_path_en && xtal_keep) |=> sec_path_en);

endmodule

// File: tb/sim_refsel_dual.sv
`timescale 1ns/1ps
module sim_refsel_dual;

  localparam int SETTLE = 80;
  localparam real MIN_PULSE = 3.4;

  logic clk_sys = 1'b0;
  logic clk_pri = 1'b0;
  logic clk_sec = 1'b0;
  logic p_run = 1'b1;
  logic rst_n = 1'b0;
  logic pri_ok = 1'b1;
  logic sec_ok = 1'b1;
  logic [1:0] mode_a = 2'b00;
  logic [1:0] mode_b = 2'b00;
  logic [1:0] pin_lvl = 2'b00;
  logic xtal_keep = 1'b0;
  logic [1:0] clk_out;
  logic los;
  logic [1:0] out_dis;
  logic [1:0] cur_sel;
  logic sec_path_en;

  int checks = 0;
  int errors = 0;
  int glitches [2] = '{0, 0};
  real last_edge [2] = '{0.0, 0.0};

  typedef struct packed {
    logic [1:0] sel;
    logic       los;
    logic [1:0] dis;
    logic       sec;
  } exp_t;

  exp_t  q_exp [$];
  string q_tag [$];

  always #2.5 clk_sys = ~clk_sys;
  always begin
    #3.5;
    if (p_run) clk_pri = ~clk_pri;
  end
  always #4.5 clk_sec = ~clk_sec;

  refsel_dual u0 (
    .clk_sys(clk_sys), .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec),
    .pri_ok(pri_ok), .sec_ok(sec_ok), .mode_a(mode_a), .mode_b(mode_b),
    .pin_lvl(pin_lvl), .xtal_keep(xtal_keep), .clk_out(clk_out), .los(los),
    .out_dis(out_dis), .cur_sel(cur_sel), .sec_path_en(sec_path_en)
  );

  // R7 runt watch on both outputs
  for (genvar i = 0; i < 2; i++) begin : g_watch
    always @(clk_out[i]) begin
      if (rst_n && ($realtime - last_edge[i]) < MIN_PULSE) glitches[i]++;
      last_edge[i] = $realtime;
    end
  end

  task automatic check1(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compare queued expectations away from the active edge.
  always @(negedge clk_sys) begin
    if (q_exp.size() > 0) begin
      exp_t e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check1(t, "cur_sel", int'(cur_sel), int'(e.sel));
      check1(t, "los", int'(los), int'(e.los));
      check1(t, "out_dis", int'(out_dis), int'(e.dis));
      check1(t, "sec_path_en", int'(sec_path_en), int'(e.sec));
    end
  end

  task automatic expect_now(input string tag, input logic [1:0] sel, input logic l,
                            input logic [1:0] dis, input logic sec);
    exp_t e;
    e.sel = sel; e.los = l; e.dis = dis; e.sec = sec;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(posedge clk_sys);
    #1;
  endtask

  task automatic expect_after(input string tag, input logic [1:0] sel, input logic l,
                              input logic [1:0] dis, input logic sec);
    repeat (SETTLE) @(posedge clk_sys);
    #1;
    expect_now(tag, sel, l, dis, sec);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk_sys);
    #1;
    expect_now("R11", 2'b00, 1'b0, 2'b11, 1'b1);   // R11 state under reset
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #150000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    do_reset();
    expect_after("R11", 2'b00, 1'b0, 2'b00, 1'b1);   // R11 primary after reset

    // R9: two-cycle drop of the primary flag is ignored
    pri_ok = 1'b0;
    repeat (2) @(posedge clk_sys);
    #1 pri_ok = 1'b1;
    expect_after("R9", 2'b00, 1'b0, 2'b00, 1'b1);

    pri_ok = 1'b0;                                    // R1 fallback
    expect_after("R1", 2'b11, 1'b0, 2'b00, 1'b1);
    pri_ok = 1'b1;                                    // R2 revert, R10 path off
    expect_after("R2", 2'b00, 1'b0, 2'b00, 1'b0);

    pri_ok = 1'b0; sec_ok = 1'b0;                     // R3 / R4 both lost
    expect_after("R3", 2'b11, 1'b1, 2'b11, 1'b0);
    sec_ok = 1'b1;
    expect_after("R4", 2'b11, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b1;                                    // R10 stays off
    expect_after("R10", 2'b00, 1'b0, 2'b00, 1'b0);

    mode_a = 2'b10; mode_b = 2'b11;                   // R5 forced codes
    expect_after("R5", 2'b10, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b0;
    expect_after("R5", 2'b10, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b1;
    mode_a = 2'b11; mode_b = 2'b10;
    expect_after("R5", 2'b01, 1'b0, 2'b00, 1'b0);

    mode_a = 2'b01; mode_b = 2'b01; pin_lvl = 2'b00;  // R6 pin low
    expect_after("R6", 2'b10, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b0;
    expect_after("R6", 2'b10, 1'b0, 2'b00, 1'b0);
    pin_lvl = 2'b01;                                  // R6 pin mid
    expect_after("R6", 2'b11, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b1;
    expect_after("R6", 2'b10, 1'b0, 2'b00, 1'b0);
    pin_lvl = 2'b10;                                  // R6 pin high
    expect_after("R6", 2'b00, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b0;
    expect_after("R6", 2'b11, 1'b0, 2'b00, 1'b0);
    pri_ok = 1'b1;
    pin_lvl = 2'b11;
    expect_after("R6", 2'b00, 1'b0, 2'b00, 1'b0);

    // R8: primary stops dead while it is the selected clock
    mode_a = 2'b00; mode_b = 2'b00;
    @(negedge clk_pri);
    #0.5 p_run = 1'b0;
    pri_ok = 1'b0;
    expect_after("R8", 2'b11, 1'b0, 2'b00, 1'b0);
    p_run = 1'b1;
    repeat (20) @(posedge clk_sys);
    #1 pri_ok = 1'b1;
    expect_after("R8", 2'b00, 1'b0, 2'b00, 1'b0);

    // R10 keep option, R11 path re-enabled by reset
    xtal_keep = 1'b1;
    pri_ok = 1'b0;
    do_reset();
    expect_after("R11", 2'b11, 1'b0, 2'b00, 1'b1);
    pri_ok = 1'b1;
    expect_after("R10", 2'b00, 1'b0, 2'b00, 1'b1);

    repeat (4) @(posedge clk_sys);
    check1("R7", "runts ch1", glitches[0], 0);
    check1("R7", "runts ch2", glitches[1], 0);
    report();
  end

endmodule